// File: doc/BRIEF.md
# Adjustable Microframe Start-of-Frame Timer

This block sets the microframe rhythm of a high-speed USB host controller. It counts periods of the bit-time clock and gives a one-cycle `sof` strobe at the end of every microframe. It also keeps a running microframe index, and the upper part of that index is the frame number. The microframe length is not fixed. It is a base count plus a fixed step for each unit of a 6-bit trim value, and the trim lets software correct for an offset in the clock source while the controller is running.

The trim value sits in a byte-wide register. Software writes it with a single-cycle write strobe and reads it back on a plain read bus. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake. A write is never refused, and the read bus always shows the current register contents. When `run` is low the timer sits idle with its counter at zero. Raising `run` starts a fresh microframe.

Top module: `usof_timer`

## Requirements
- R1: The microframe length P, counted in clock cycles, is BASE_CNT + STEP_CNT × trim, where trim is the 6-bit trim value. With the defaults (59488 and 16) the trim values 0 to 63 give lengths of 59488 to 60496.
- R2: The trim value occupies bits 5:0 of the 8-bit register. A cycle with `reg_wr_en` high stores `reg_wr_data[5:0]` at that clock edge. From the next cycle on, `reg_rd_data[5:0]` shows the stored value.
- R3: Bits 7:6 of `reg_rd_data` always read 0. Whatever is written to bits 7:6 is ignored, and only bits 5:0 affect the length.
- R4: The trim value resets to 20h, which gives a length of BASE_CNT + 32 × STEP_CNT (60000 with the defaults).
- R5: A trim write made during a microframe leaves the length of that microframe unchanged. The new length applies from the next microframe boundary onward.
- R6: `sof` is high for exactly one cycle per microframe, in the cycle where the internal count equals P−1. The count then wraps to zero, so strobes come exactly P cycles apart.
- R7: While `run` is low the count is held at zero and `sof` stays low. After `run` goes high, the first `sof` is in the P-th consecutive cycle with `run` high. That first frame uses the trim value present while the timer was idle.
- R8: The 14-bit `uframe_idx` advances by one on the clock edge that ends each `sof` cycle and wraps from 16383 to 0. `frame_num` equals `uframe_idx[13:3]`. The index holds its value while `run` is low.
- R9: A synchronous active-high `rst` sets the trim to 20h, clears the count and the index, and keeps `sof` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Timer enable; when low the counter is held at zero |
| reg_wr_en | input | 1 | Write strobe for the trim register |
| reg_wr_data | input | 8 | Write data; bits 7:6 are ignored |
| reg_rd_data | output | 8 | Register read-back; bits 7:6 always read 0 |
| sof | output | 1 | One-cycle start-of-frame strobe |
| uframe_idx | output | 14 | Microframe index |
| frame_num | output | 11 | Frame number, equal to the upper 11 bits of the index |

## Verification
`sof` is a combinational decode of the count, so it is visible in the P-th cycle of a frame. The index moves one edge after that cycle, and the read-back data one edge after a write. The bench changes its inputs 1 ns after a rising edge and samples on the falling edge. The monitor counts the sampled cycles in which `run` is high and compares that count, at each strobe, with the length the driver queued. At the same strobe it checks that the index still holds its value from before the increment. The bench overrides BASE_CNT to 3 so that the 16384-frame wrap of the index fits in the run time, and keeps the step at 16.

// File: rtl/usof_pkg.sv
package usof_pkg;
  localparam int ADJ_W = 6;
  localparam int REG_W = 8;
  localparam logic [ADJ_W-1:0] ADJ_RST = 6'h20;
endpackage

// File: rtl/usof_adj_reg.sv
module usof_adj_reg
  import usof_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [ADJ_W-1:0] adj_o,
  output logic [REG_W-1:0] rd_data
);
  logic [ADJ_W-1:0] adj_q;

  always_ff @(posedge clk) begin
    if (rst)        adj_q <= ADJ_RST;
    else if (wr_en) adj_q <= wr_data[ADJ_W-1:0];
  end

  assign adj_o = adj_q;

  // Trim bits read back as stored; reserved bits are tied to zero.
  for (genvar i = 0; i < REG_W; i++) begin : g_rd
    if (i < ADJ_W) begin : g_live
      assign rd_data[i] = adj_q[i];
    end else begin : g_rsvd
      assign rd_data[i] = 1'b0;
    end
  end

  a_r2_wr_store: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> adj_q == $past(wr_data[ADJ_W-1:0]));
  a_r2_no_wr_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(adj_q));
endmodule

// File: rtl/usof_period_ctr.sv
module usof_period_ctr
  import usof_pkg::*;
#(
  parameter int BASE_CNT = 59488,
  parameter int STEP_CNT = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ADJ_W-1:0] adj_i,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] P_RST = CNT_W'(BASE_CNT + STEP_CNT * int'(ADJ_RST));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] period_nx;
  logic             tick;

  assign period_nx = CNT_W'(BASE_CNT) + CNT_W'(STEP_CNT) * CNT_W'(adj_i);
  assign tick      = run && (cnt_q == period_q - 1'b1);
  assign tick_o    = tick;

  // The frame length is taken only at a boundary or while idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= P_RST;
    end else if (!run) begin
      cnt_q    <= '0;
      period_q <= period_nx;
    end else if (tick) begin
      cnt_q    <= '0;
      period_q <= period_nx;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  a_r5_len_frozen: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(period_q));
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < period_q);
  a_r7_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  a_r1_len_loaded: assert property (@(posedge clk) disable iff (rst)
    tick |=> period_q == $past(period_nx));
endmodule

// File: rtl/usof_frame_idx.sv
module usof_frame_idx #(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (tick) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  a_r8_idx_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> idx_q == $past(idx_q) + 1'b1);
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(idx_q));
endmodule

// File: rtl/usof_timer.sv
module usof_timer
  import usof_pkg::*;
#(
  parameter int BASE_CNT  = 59488,
  parameter int STEP_CNT  = 16,
  parameter int IDX_W     = 14,
  parameter int FRM_SHIFT = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic                       reg_wr_en,
  input  logic [REG_W-1:0]           reg_wr_data,
  output logic [REG_W-1:0]           reg_rd_data,
  output logic                       sof,
  output logic [IDX_W-1:0]           uframe_idx,
  output logic [IDX_W-FRM_SHIFT-1:0] frame_num
);
  localparam int MAX_P = BASE_CNT + STEP_CNT * ((1 << ADJ_W) - 1);
  localparam int CNT_W = $clog2(MAX_P + 1);

  logic [ADJ_W-1:0] adj;
  logic             tick;

  usof_adj_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .adj_o   (adj),
    .rd_data (reg_rd_data)
  );

  usof_period_ctr #(
    .BASE_CNT (BASE_CNT),
    .STEP_CNT (STEP_CNT),
    .CNT_W    (CNT_W)
  ) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .adj_i  (adj),
    .tick_o (tick)
  );

  usof_frame_idx #(
    .IDX_W (IDX_W)
  ) u_idx (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .idx_o (uframe_idx)
  );

  assign sof       = tick;
  assign frame_num = uframe_idx[IDX_W-1:FRM_SHIFT];

  a_r6_sof_single: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sof);
  a_r3_rsvd_read: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> reg_rd_data[REG_W-1:ADJ_W] == '0);
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (reg_rd_data == {{(REG_W-ADJ_W){1'b0}}, ADJ_RST} && uframe_idx == '0 && !sof));
endmodule

// File: tb/sim_usof_timer.sv
module sim_usof_timer;
  localparam int BASE = 3;
  localparam int STEP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wr_data = '0;
  logic [7:0]  reg_rd_data;
  logic        sof;
  logic [13:0] uframe_idx;
  logic [10:0] frame_num;

  int n_chk = 0;
  int n_bad = 0;
  int q[$];
  int cyc = 0;
  int exp_idx = 0;
  int cur_len;
  bit done = 0;

  always #2.5 clk = ~clk;

  usof_timer #(.BASE_CNT(BASE), .STEP_CNT(STEP)) u0 (
    .clk(clk), .rst(rst), .run(run), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .sof(sof),
    .uframe_idx(uframe_idx), .frame_num(frame_num)
  );

  function automatic int flen(int a);
    return BASE + STEP * a;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measures each frame and checks the index at every strobe.
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
      exp_idx = 0;
    end else begin
      if (run) cyc++;
      else begin
        cyc = 0;
        chk(!sof, "R7 sof while idle", int'(sof), 0);
      end
      if (sof) begin
        if (q.size() == 0) chk(1'b0, "R6 unexpected sof", cyc, 0);
        else begin
          int e;
          e = q.pop_front();
          chk(cyc == e, "R1/R5/R6 frame length", cyc, e);
        end
        chk(int'(uframe_idx) == exp_idx, "R8 index", int'(uframe_idx), exp_idx);
        chk(int'(frame_num) == (exp_idx >> 3), "R8 frame_num", int'(frame_num), exp_idx >> 3);
        exp_idx = (exp_idx + 1) % 16384;
        cyc = 0;
      end
    end
  end

  task automatic push(int len, int n);
    for (int i = 0; i < n; i++) q.push_back(len);
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] v);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_data = v;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_wr_data = '0;
    @(negedge clk);
    chk(reg_rd_data == {2'b00, v[5:0]}, "R2/R3 readback", int'(reg_rd_data), int'({2'b00, v[5:0]}));
    @(posedge clk); #1;
  endtask

  // Write a new trim mid-frame: the frame in progress keeps its length.
  task automatic step(logic [7:0] v, int n);
    push(cur_len, 1);
    wr(v);
    cur_len = flen(int'(v[5:0]));
    push(cur_len, n);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reg_rd_data == 8'h20, "R4/R9 reset trim", int'(reg_rd_data), 32);
    chk(!sof, "R9 reset sof", int'(sof), 0);
    chk(uframe_idx == 0, "R9 reset index", int'(uframe_idx), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
    cur_len = flen(32);
    push(cur_len, 3);
    run = 1'b1;
    drain();
    step(8'h05, 4);
    step(8'hFF, 2);   // R3: bits 7:6 ignored, length uses 63
    // R7: idle holds the count and the index
    run = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!sof, "R7 idle no sof", int'(sof), 0);
    end
    @(posedge clk); #1;
    wr(8'h05);
    cur_len = flen(5);
    push(cur_len, 2);
    run = 1'b1;
    drain();
    // R8: run to the index wrap with the shortest frame
    step(8'h00, 16384);
    // R9: mid-run reset restores trim and restarts the frame
    rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(reg_rd_data == 8'h20, "R9 trim after reset", int'(reg_rd_data), 32);
    chk(uframe_idx == 0, "R9 index after reset", int'(uframe_idx), 0);
    @(posedge clk); #1;
    cur_len = flen(32);
    push(cur_len, 1);
    rst = 1'b0;
    drain();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule